// File: doc/BRIEF.md
# Burst-Threshold Output Drain Controller

This block holds the encoded output of a second-stage encoder in a circular byte store and hands it to a DMA engine in fixed bursts. The encoder writes whole bytes one at a time. It closes each frame with a done pulse, which can carry a last partial byte. That byte is padded with zero bits, so every frame ends on a byte boundary and the next frame follows with no gap.

The fill level is compared with the burst size only on a frame-done pulse, and only while no drain is running. If a full burst is buffered at that point, a read request is raised. The request stays up until exactly one burst of bytes has been read. At end of stream, software sets a flush bit. This drains whatever partial remainder is buffered, records how many bytes were drained, and clears the bit by itself. A write into a full store is dropped and sets a sticky error flag.

Top module: `drain_ctrl`

## Requirements
- R1: After reset, `dma_req`, `fill_level`, `ovf_err`, `flush_busy` and `flush_count` are all zero.
- R2: Bytes leave on `dma_data` in the order they were committed. `fill_level` equals committed bytes minus read bytes, and it is updated one cycle after each write or read.
- R3: On `frame_done` with `tail_bits` = k in 1..7, one byte is committed. Its upper k bits are taken from `tail_data` and its lower 8-k bits are zero. With k = 0 nothing is committed. `wr_valid` and `frame_done` are never high in the same cycle.
- R4: The threshold is evaluated only on a `frame_done` cycle. If the controller is idle, no flush is pending, and the fill after that cycle's commit is at least `BURST` bytes, then `dma_req` is high from the next cycle on. Byte writes alone never raise a request.
- R5: A threshold drain keeps `dma_req` high for exactly `BURST` accepted reads (`dma_rd` high while `dma_req` is high), then drops it. Any bytes beyond the burst stay buffered.
- R6: A `frame_done` that arrives while a drain is running, or while the flush bit is set, starts nothing. The threshold is not re-checked when a drain ends.
- R7: A pulse on `flush_set` sets `flush_busy`. Once no drain is running, the current fill is captured into `flush_count`, `dma_req` stays high for exactly that many reads, and `flush_busy` then clears. With an empty store, `flush_busy` clears without any request. A pending flush takes precedence over a threshold drain.
- R8: A byte committed while the store holds `DEPTH` bytes is discarded, and `ovf_err` is set and stays set until reset.
- R9: `dma_rd` while `dma_req` is low has no effect on the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Encoder byte write strobe |
| wr_data | input | 8 | Encoder byte |
| frame_done | input | 1 | End-of-frame pulse |
| tail_bits | input | 3 | Valid bits in the final partial byte (0 = none) |
| tail_data | input | 8 | Final partial byte, MSB-aligned |
| flush_set | input | 1 | Software write that sets the forced-flush bit |
| dma_rd | input | 1 | DMA byte read strobe |
| dma_req | output | 1 | DMA read request |
| dma_data | output | 8 | Byte at the read pointer |
| fill_level | output | $clog2(DEPTH)+1 | Bytes buffered |
| flush_busy | output | 1 | Forced-flush bit readback |
| flush_count | output | $clog2(DEPTH)+1 | Bytes drained by the last forced flush |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
Several properties are checked on every cycle:
- a threshold drain never starts below one burst;
- the store is never popped while empty and never holds more than `DEPTH` bytes;
- an active request always has bytes left to deliver;
- the overflow flag stays set once raised;
- the encoder never drives both write strobes at once.

Other behaviour can only be shown by bench scenarios:
- the byte order and tail padding seen on the read port;
- that exactly one burst is delivered per drain;
- that a frame-done pulse is ignored during a drain and the threshold is not re-checked at its end;
- that a pending flush drains the whole remainder and reports its count.

// File: rtl/drain_pkg.sv
package drain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NORM  = 2'd1,
    ST_FLUSH = 2'd2
  } drain_st_e;

  // keep the k most significant bits of a tail byte, zero the rest
  function automatic logic [7:0] pad_tail(logic [7:0] d, logic [2:0] k);
    logic [7:0] keep;
    keep = ~(8'hFF >> k);
    return d & keep;
  endfunction

endpackage

// File: rtl/drain_buf.sv
module drain_buf #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    pop_data,
  output logic [FW-1:0] fill,
  output logic          push_drop,
  output logic          ovf_err
);
  logic [7:0]    mem [DEPTH];
  logic [FW-1:0] wp, rp;
  logic          full, push_ok;

  assign fill      = wp - rp;
  assign full      = (fill == FW'(DEPTH));
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (push_ok)   wp <= wp + 1'b1;
      if (pop)       rp <= rp + 1'b1;
      if (push_drop) ovf_err <= 1'b1;
    end
  end

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> fill != '0);                                          // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));                                          // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);                                         // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_err);                                       // R8
endmodule

// File: rtl/drain_sched.sv
module drain_sched
  import drain_pkg::*;
#(
  parameter int BURST = 4096,
  parameter int FW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_evt,
  input  logic [FW-1:0] fill_now,
  input  logic [FW-1:0] fill_after,
  input  logic          flush_set,
  input  logic          rd_fire,
  output logic          dma_req,
  output logic          flush_busy,
  output logic [FW-1:0] flush_count
);
  drain_st_e     st;
  logic [FW-1:0] rem;
  logic          norm_start, last_rd;

  assign dma_req    = (st != ST_IDLE);
  assign norm_start = frame_evt && (st == ST_IDLE) && !flush_busy
                      && (fill_after >= FW'(BURST));
  assign last_rd    = rd_fire && (rem == FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      rem         <= '0;
      flush_busy  <= 1'b0;
      flush_count <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (flush_busy) begin
            flush_count <= fill_now;
            if (fill_now == '0) flush_busy <= 1'b0;
            else begin
              rem <= fill_now;
              st  <= ST_FLUSH;
            end
          end else if (norm_start) begin
            rem <= FW'(BURST);
            st  <= ST_NORM;
          end
        end
        default: begin
          if (rd_fire) rem <= rem - 1'b1;
          if (last_rd) begin
            st <= ST_IDLE;
            if (st == ST_FLUSH) flush_busy <= 1'b0;
          end
        end
      endcase
      if (flush_set) flush_busy <= 1'b1;
    end
  end

  AST_NORM_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_NORM) |-> fill_now >= FW'(BURST));             // R4
  AST_REQ_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rem != '0);                                       // R5
  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH) |-> flush_busy);                             // R7
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl
  import drain_pkg::*;
#(
  parameter int BURST = 4096,
  parameter int DEPTH = 4096,
  localparam int FW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          frame_done,
  input  logic [2:0]    tail_bits,
  input  logic [7:0]    tail_data,
  input  logic          flush_set,
  input  logic          dma_rd,
  output logic          dma_req,
  output logic [7:0]    dma_data,
  output logic [FW-1:0] fill_level,
  output logic          flush_busy,
  output logic [FW-1:0] flush_count,
  output logic          ovf_err
);
  logic          push, push_drop, rd_fire;
  logic [7:0]    push_data;
  logic [FW-1:0] fill_after;

  assign push       = wr_valid || (frame_done && (tail_bits != 3'd0));
  assign push_data  = frame_done ? pad_tail(tail_data, tail_bits) : wr_data;
  assign rd_fire    = dma_rd && dma_req;
  assign fill_after = fill_level + FW'(push && !push_drop);

  drain_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data),
    .pop(rd_fire), .pop_data(dma_data),
    .fill(fill_level), .push_drop(push_drop), .ovf_err(ovf_err)
  );

  drain_sched #(.BURST(BURST), .FW(FW)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .frame_evt(frame_done), .fill_now(fill_level), .fill_after(fill_after),
    .flush_set(flush_set), .rd_fire(rd_fire),
    .dma_req(dma_req), .flush_busy(flush_busy), .flush_count(flush_count)
  );

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && frame_done));                                   // R3
endmodule

// File: tb/drain_ctrl_bench.sv
module drain_ctrl_bench;
  localparam int CLK_T = 10;
  localparam int BURST = 16;
  localparam int DEPTH = 32;
  localparam int FW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, frame_done = 0, flush_set = 0, dma_rd = 0;
  logic [7:0] wr_data = 0, tail_data = 0;
  logic [2:0] tail_bits = 0;
  logic dma_req, flush_busy, ovf_err;
  logic [7:0] dma_data;
  logic [FW-1:0] fill_level, flush_count;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] q[$];

  always #(CLK_T/2) clk = ~clk;

  drain_ctrl #(.BURST(BURST), .DEPTH(DEPTH)) u_drain_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .frame_done(frame_done), .tail_bits(tail_bits), .tail_data(tail_data),
    .flush_set(flush_set), .dma_rd(dma_rd), .dma_req(dma_req),
    .dma_data(dma_data), .fill_level(fill_level), .flush_busy(flush_busy),
    .flush_count(flush_count), .ovf_err(ovf_err));

  function automatic logic [7:0] exp_tail(logic [7:0] d, int k);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < k; i++) r[7-i] = d[7-i];
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    wr_valid = 1; wr_data = b;
    @(negedge clk);
    wr_valid = 0;
    if (q.size() < DEPTH) q.push_back(b);
  endtask

  task automatic frame(int k, logic [7:0] d);
    frame_done = 1; tail_bits = 3'(k); tail_data = d;
    @(negedge clk);
    frame_done = 0;
    if (k != 0 && q.size() < DEPTH) q.push_back(exp_tail(d, k));
  endtask

  task automatic take(int n, string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " req during drain"}, dma_req, 1);
      chk({req, " data order"}, dma_data, q[0]);
      dma_rd = 1;
      @(negedge clk);
      void'(q.pop_front());
    end
    dma_rd = 0;
    chk({req, " req drops after count"}, dma_req, 0);
  endtask

  task automatic flush_all(string req);
    int n;
    n = q.size();
    flush_set = 1;
    @(negedge clk);
    flush_set = 0;
    chk({req, " flush bit set"}, flush_busy, 1);
    @(negedge clk);
    chk({req, " flush count"}, flush_count, n);
    if (n > 0) take(n, req);
    chk({req, " flush bit auto-clear"}, flush_busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", dma_req, 0);
    chk("R1 fill", fill_level, 0);
    chk("R1 ovf", ovf_err, 0);
    chk("R1 flush", flush_busy, 0);
    chk("R1 count", flush_count, 0);

    // R9 read while idle
    dma_rd = 1; @(negedge clk); dma_rd = 0;
    chk("R9 fill unchanged", fill_level, 0);

    // R3 padding directed
    frame(0, 8'hAA);
    chk("R3 k0 commits nothing", fill_level, 0);
    frame(3, 8'hFF);
    chk("R3 padded byte committed", fill_level, 1);
    chk("R4 below burst no req", dma_req, 0);
    chk("R3 pad value", dma_data, 8'hE0);
    flush_all("R7");

    // R2 R4 R5 random frames
    for (int f = 0; f < 40; f++) begin
      int n, k;
      n = $urandom % 12;
      k = $urandom % 8;
      for (int b = 0; b < n; b++) put(8'($urandom));
      frame(k, 8'($urandom));
      chk("R2 fill tracks", fill_level, q.size());
      chk("R4 threshold at frame end", dma_req, (q.size() >= BURST) ? 1 : 0);
      if (dma_req) begin
        take(BURST, "R5");
        chk("R5 remainder kept", fill_level, q.size());
      end
    end
    flush_all("R7 residue");

    // R7 flush at empty
    flush_set = 1; @(negedge clk); flush_set = 0;
    @(negedge clk);
    chk("R7 empty no req", dma_req, 0);
    chk("R7 empty bit clears", flush_busy, 0);
    chk("R7 empty count", flush_count, 0);

    // R4 writes alone never request
    for (int b = 0; b < 20; b++) put(8'(b + 100));
    repeat (3) @(negedge clk);
    chk("R4 no req without frame_done", dma_req, 0);
    // R6 frame_done while flush pending: flush wins, drains all
    flush_set = 1; @(negedge clk); flush_set = 0;
    frame(0, 8'h00);
    chk("R6 flush precedence count", flush_count, 20);
    take(20, "R6");
    chk("R6 flush cleared", flush_busy, 0);

    // R6 frame_done during drain ignored, no re-check at drain end
    for (int b = 0; b < 31; b++) put(8'($urandom));
    frame(0, 8'h00);
    chk("R4 req on frame end", dma_req, 1);
    for (int i = 0; i < 2; i++) begin
      chk("R2 data order", dma_data, q[0]);
      dma_rd = 1; @(negedge clk); void'(q.pop_front());
    end
    dma_rd = 0;
    frame(3, 8'h5A);
    take(BURST - 2, "R6");
    chk("R6 fill after drain", fill_level, 16);
    repeat (2) @(negedge clk);
    chk("R6 no re-check at drain end", dma_req, 0);
    frame(0, 8'h00);
    chk("R4 next frame end requests", dma_req, 1);
    take(BURST, "R5");
    chk("R5 store empty", fill_level, 0);

    // R8 overflow
    for (int b = 0; b < DEPTH + 2; b++) put(8'(b * 3));
    chk("R8 fill capped", fill_level, DEPTH);
    chk("R8 ovf set", ovf_err, 1);
    flush_all("R8");
    chk("R8 ovf sticky", ovf_err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule